// File: doc/BRIEF.md
# Integer ALU with status flags

This block is the integer arithmetic and logic stage of a datapath. Each cycle in which `valid_i` is high it takes an opcode, a size select and two operands. It produces a result at 8, 16 or 32 bits. It also updates a six-bit status register that holds carry, parity, auxiliary carry, zero, sign and overflow.

The arithmetic group covers add, add with carry, subtract, subtract with borrow, increment, decrement, compare and negate. The logic group covers AND, OR, XOR and NOT. Three further opcodes set, clear or complement the carry flag on their own.

The result, the write-back strobe and the flags are all registered, so they appear one cycle after the request. Operations can be issued back to back on consecutive cycles. The carry-in of add with carry and subtract with borrow is the carry flag as left by the operation just before, so a multi-word add or subtract can be chained one word per cycle.

Top module: `int_alu`

## Requirements
- R1: One clock edge after a cycle with `valid_i` high, `result_o`, `wb_o` and `flags_o` show that operation. `wb_o` is high for exactly that one cycle when the opcode writes a result. In cycles that follow no request, `wb_o` is 0 and `result_o` and `flags_o` hold.
- R2: ADD (opcode 0) yields a+b. ADC (1) yields a+b+carry. Carry (flags bit 0) is set when a one leaves the top bit of the selected width.
- R3: SUB (2) yields a-b. SBB (3) yields a-b-carry. NEG (7) yields 0-a. For all three, carry is set when a borrow enters the top bit.
- R4: Overflow (flags bit 5) is set for an addition when both addends have equal signs and the result's sign differs. For a subtraction it is set when the operand signs differ and the result's sign differs from the minuend.
- R5: Auxiliary carry (flags bit 2) is the carry, or for subtraction the borrow, between bit 3 and bit 4.
- R6: Zero (flags bit 3) is set exactly when the result at the selected width is all zero. Sign (flags bit 4) is the top bit of that result. Parity (flags bit 1) is set when the low result byte holds an even number of ones.
- R7: INC (4) yields a+1 and DEC (5) yields a-1. Both update every flag except carry, which keeps its previous value.
- R8: CMP (6) updates the flags exactly as SUB would. It does not write back: `wb_o` stays 0 and `result_o` keeps its value.
- R9: AND (8), OR (9) and XOR (10) write back the bitwise result. They clear carry, overflow and auxiliary carry, and they update sign, zero and parity.
- R10: NOT (11) writes back the inverted operand a at the selected width and leaves all six flags unchanged.
- R11: Set-carry (12), clear-carry (13) and complement-carry (14) force carry to 1, force it to 0, or invert it. They leave the other flags unchanged and do not write back.
- R12: The size select is 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. Operand bits above the selected width have no effect, and the result bits above it are 0.
- R13: After reset, `result_o`, `wb_o` and `flags_o` are 0. Opcode 15 writes nothing and changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Opcode |
| size_i | input | 2 | Operand width select |
| a_i | input | 32 | First operand (minuend, or the operand for single-operand ops) |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Registered result, updated on write-back |
| wb_o | output | 1 | Write-back enable, one cycle per writing operation |
| flags_o | output | 6 | Flags: 0 carry, 1 parity, 2 aux carry, 3 zero, 4 sign, 5 overflow |

## Verification
Some properties are checked on every cycle:
- flags and result hold when no request came;
- zero agrees with the written result;
- upper result bits are clear for byte operations;
- carry is kept across increment and decrement, and its value after the three carry opcodes;
- logic operations clear carry and overflow;
- NOT leaves the flags alone;
- compare never writes back.

The numeric correctness of sums, differences, borrows, overflow and auxiliary carry at each width can only be shown by the scenarios, which compare every response against an independent arithmetic model. The same holds for carry chaining through ADC and SBB.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int DW  = 32;
  localparam int NSZ = 3;   // 8, 16, 32
  localparam int FW  = 6;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_INC = 4'd4,  OP_DEC = 4'd5,  OP_CMP = 4'd6,  OP_NEG = 4'd7,
    OP_AND = 4'd8,  OP_OR  = 4'd9,  OP_XOR = 4'd10, OP_NOT = 4'd11,
    OP_STC = 4'd12, OP_CLC = 4'd13, OP_CMC = 4'd14, OP_RSV = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_WX = 2'd3
  } sz_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2, LG_NOT = 2'd3
  } lg_e;

  // cf is bit 0
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;

  function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_B:    size_mask = DW'(32'h0000_00ff);
      SZ_H:    size_mask = DW'(32'h0000_ffff);
      default: size_mask = '1;
    endcase
  endfunction

  function automatic int unsigned size_idx(input logic [1:0] sz);
    case (sz)
      SZ_B:    size_idx = 0;
      SZ_H:    size_idx = 1;
      default: size_idx = NSZ - 1;
    endcase
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import int_alu_pkg::*;
#(
  parameter int W_DATA = DW
) (
  input  logic [W_DATA-1:0] x_i,
  input  logic [W_DATA-1:0] y_i,
  input  logic              ci_i,   // carry or borrow in
  input  logic              sub_i,
  input  logic [1:0]        sz_i,
  output logic [W_DATA-1:0] res_o,
  output logic              cy_o,
  output logic              ov_o,
  output logic              af_o
);
  logic [W_DATA-1:0] y_eff;
  logic              c_eff;
  logic [W_DATA-1:0] res_s [NSZ];
  logic [NSZ-1:0]    cy_s;
  logic [NSZ-1:0]    ov_s;

  // subtraction as x + ~y + ~borrow
  assign y_eff = sub_i ? ~y_i : y_i;
  assign c_eff = ci_i ^ sub_i;

  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    localparam int W = 8 << g;
    logic [W:0] s;
    assign s = {1'b0, x_i[W-1:0]} + {1'b0, y_eff[W-1:0]} + (W+1)'(c_eff);
    if (W < W_DATA) begin : g_pad
      assign res_s[g] = {{(W_DATA-W){1'b0}}, s[W-1:0]};
    end else begin : g_full
      assign res_s[g] = s[W_DATA-1:0];
    end
    assign cy_s[g] = s[W] ^ sub_i;
    assign ov_s[g] = (x_i[W-1] ~^ y_eff[W-1]) & (s[W-1] ^ x_i[W-1]);
  end

  always_comb begin
    res_o = res_s[size_idx(sz_i)];
    cy_o  = cy_s[size_idx(sz_i)];
    ov_o  = ov_s[size_idx(sz_i)];
  end

  assign af_o = x_i[4] ^ y_i[4] ^ res_o[4];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import int_alu_pkg::*;
#(
  parameter int W_DATA = DW
) (
  input  logic [W_DATA-1:0] x_i,
  input  logic [W_DATA-1:0] y_i,
  input  logic [W_DATA-1:0] mask_i,
  input  logic [1:0]        fn_i,
  output logic [W_DATA-1:0] res_o
);
  always_comb begin
    case (lg_e'(fn_i))
      LG_AND:  res_o = x_i & y_i;
      LG_OR:   res_o = x_i | y_i;
      LG_XOR:  res_o = x_i ^ y_i;
      default: res_o = ~x_i & mask_i;
    endcase
  end
endmodule

// File: rtl/alu_status.sv
module alu_status
  import int_alu_pkg::*;
#(
  parameter int W_DATA = DW
) (
  input  logic [W_DATA-1:0] res_i,  // already masked to size
  input  logic [1:0]        sz_i,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o
);
  assign zf_o = (res_i == '0);
  assign pf_o = ~^res_i[7:0];

  always_comb begin
    case (sz_i)
      SZ_B:    sf_o = res_i[7];
      SZ_H:    sf_o = res_i[15];
      default: sf_o = res_i[W_DATA-1];
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W_DATA = DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [W_DATA-1:0] a_i,
  input  logic [W_DATA-1:0] b_i,
  output logic [W_DATA-1:0] result_o,
  output logic              wb_o,
  output logic [FW-1:0]     flags_o
);
  op_e               op;
  logic [W_DATA-1:0] mask, a_m, b_m;
  logic [W_DATA-1:0] as_x, as_y, as_res, lg_res, res_sel;
  logic              as_ci, as_sub, as_cy, as_ov, as_af;
  logic              use_logic;
  logic              zf, sf, pf;
  flags_t            fl_q, fl_n;
  logic [W_DATA-1:0] res_q;
  logic              wb_q, wb_n;

  assign op   = op_e'(op_i);
  assign mask = size_mask(size_i);
  assign a_m  = a_i & mask;
  assign b_m  = b_i & mask;

  // operand steering for the shared adder
  always_comb begin
    as_x      = a_m;
    as_y      = b_m;
    as_ci     = 1'b0;
    as_sub    = 1'b0;
    use_logic = 1'b0;
    case (op)
      OP_ADC:                 as_ci  = fl_q.cf;
      OP_SUB, OP_CMP:         as_sub = 1'b1;
      OP_SBB: begin           as_sub = 1'b1; as_ci = fl_q.cf; end
      OP_INC:                 as_y   = W_DATA'(1);
      OP_DEC: begin           as_y   = W_DATA'(1); as_sub = 1'b1; end
      OP_NEG: begin           as_x   = '0; as_y = a_m; as_sub = 1'b1; end
      OP_AND, OP_OR, OP_XOR, OP_NOT: use_logic = 1'b1;
      default: ;
    endcase
  end

  alu_addsub #(.W_DATA(W_DATA)) u_addsub (
    .x_i   (as_x),
    .y_i   (as_y),
    .ci_i  (as_ci),
    .sub_i (as_sub),
    .sz_i  (size_i),
    .res_o (as_res),
    .cy_o  (as_cy),
    .ov_o  (as_ov),
    .af_o  (as_af)
  );

  alu_logic #(.W_DATA(W_DATA)) u_logic (
    .x_i    (a_m),
    .y_i    (b_m),
    .mask_i (mask),
    .fn_i   (op_i[1:0]),
    .res_o  (lg_res)
  );

  assign res_sel = use_logic ? lg_res : as_res;

  alu_status #(.W_DATA(W_DATA)) u_status (
    .res_i (res_sel),
    .sz_i  (size_i),
    .zf_o  (zf),
    .sf_o  (sf),
    .pf_o  (pf)
  );

  always_comb begin
    fl_n = fl_q;
    wb_n = 1'b0;
    if (valid_i) begin
      case (op)
        OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG, OP_CMP: begin
          fl_n = '{of: as_ov, sf: sf, zf: zf, af: as_af, pf: pf, cf: as_cy};
          wb_n = (op != OP_CMP);
        end
        OP_INC, OP_DEC: begin
          fl_n = '{of: as_ov, sf: sf, zf: zf, af: as_af, pf: pf, cf: fl_q.cf};
          wb_n = 1'b1;
        end
        OP_AND, OP_OR, OP_XOR: begin
          fl_n = '{of: 1'b0, sf: sf, zf: zf, af: 1'b0, pf: pf, cf: 1'b0};
          wb_n = 1'b1;
        end
        OP_NOT: wb_n = 1'b1;
        OP_STC: fl_n.cf = 1'b1;
        OP_CLC: fl_n.cf = 1'b0;
        OP_CMC: fl_n.cf = ~fl_q.cf;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q  <= '0;
      res_q <= '0;
      wb_q  <= 1'b0;
    end else begin
      fl_q <= fl_n;
      wb_q <= wb_n;
      if (wb_n) res_q <= res_sel;
    end
  end

  assign result_o = res_q;
  assign wb_o     = wb_q;
  assign flags_o  = fl_q;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int W_DATA = DW
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [1:0]        size_i,
  input logic [W_DATA-1:0] result_o,
  input logic              wb_o,
  input logic [FW-1:0]     flags_o
);
  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> (!wb_o && $stable(flags_o) && $stable(result_o)));

  assert_zero_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_o && $past(op_i) != OP_NOT) |-> (flags_o[3] == (result_o == '0)));

  assert_keep_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && (op_i == OP_INC || op_i == OP_DEC)) |-> (flags_o[0] == $past(flags_o[0])));

  assert_cmp_no_wb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i == OP_CMP) |-> (!wb_o && $stable(result_o)));

  assert_logic_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR))
      |-> (!flags_o[0] && !flags_o[5] && !flags_o[2]));

  assert_not_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i == OP_NOT) |-> $stable(flags_o));

  assert_set_carry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i == OP_STC) |-> (flags_o[0] && !wb_o));

  assert_cmc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i == OP_CMC) |-> (flags_o[0] != $past(flags_o[0])));

  assert_byte_upper_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_o && $past(size_i) == SZ_B) |-> (result_o[W_DATA-1:8] == '0));
endmodule

bind int_alu int_alu_chk #(.W_DATA(W_DATA)) u_chk (.*);

// File: tb/tb_int_alu.sv
`timescale 1ns/1ps
module tb_int_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  sz = '0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] result;
  logic        wb;
  logic [5:0]  flags;

  always #4 clk = ~clk;  // 125 MHz

  int_alu dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .size_i(sz),
    .a_i(a), .b_i(b), .result_o(result), .wb_o(wb), .flags_o(flags)
  );

  typedef struct {
    logic        wb;
    logic [31:0] res;
    logic [5:0]  fl;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          fails = 0;
  logic [5:0]  m_fl = '0;
  logic [31:0] m_res = '0;

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      0, 1:      return "R2";
      2, 3, 7:   return "R3";
      4, 5:      return "R7";
      6:         return "R8";
      8, 9, 10:  return "R9";
      11:        return "R10";
      12, 13, 14: return "R11";
      default:   return "R13";
    endcase
  endfunction

  // independent reference: wide signed arithmetic, then masking
  function automatic exp_t model(input logic [3:0] o, input logic [1:0] s,
                                 input logic [31:0] ia, input logic [31:0] ib);
    exp_t e;
    int w = (s == 0) ? 8 : (s == 1) ? 16 : 32;
    longint mask = (longint'(1) << w) - 1;
    longint x = longint'(ia) & mask;
    longint y = longint'(ib) & mask;
    longint c = 0, full, r = 0;
    bit arith = 0, is_sub = 0, keepc = 0, wbe = 0;
    bit cf, of, af, sx, sy, sr, pf;
    logic [7:0] lb;
    logic [5:0] f = m_fl;
    case (o)
      0, 1:    begin arith = 1; c = (o == 1) ? longint'(m_fl[0]) : 0; end
      2, 3, 6: begin arith = 1; is_sub = 1; c = (o == 3) ? longint'(m_fl[0]) : 0; end
      4:       begin arith = 1; y = 1; keepc = 1; end
      5:       begin arith = 1; y = 1; keepc = 1; is_sub = 1; end
      7:       begin arith = 1; is_sub = 1; y = x; x = 0; end
      default: ;
    endcase
    if (arith) begin
      full = is_sub ? (x - y - c) : (x + y + c);
      r  = full & mask;
      cf = is_sub ? (full < 0) : bit'((full >> w) & 1);
      sx = bit'((x >> (w - 1)) & 1);
      sy = bit'((y >> (w - 1)) & 1);
      sr = bit'((r >> (w - 1)) & 1);
      of = is_sub ? (sx != sy && sr != sx) : (sx == sy && sr != sx);
      af = bit'(((x ^ y ^ r) >> 4) & 1);
      lb = r[7:0];
      pf = ($countones(lb) % 2) == 0;
      f  = {of, sr, r == 0, af, pf, keepc ? m_fl[0] : cf};
      wbe = (o != 6);
    end else begin
      case (o)
        8, 9, 10, 11: begin
          r = (o == 8) ? (x & y) : (o == 9) ? (x | y) : (o == 10) ? (x ^ y) : (~x & mask);
          sr = bit'((r >> (w - 1)) & 1);
          lb = r[7:0];
          pf = ($countones(lb) % 2) == 0;
          if (o != 11) f = {1'b0, sr, r == 0, 1'b0, pf, 1'b0};
          wbe = 1;
        end
        12: f[0] = 1'b1;
        13: f[0] = 1'b0;
        14: f[0] = ~m_fl[0];
        default: ;
      endcase
    end
    if (wbe) m_res = r[31:0];
    m_fl  = f;
    e.wb  = wbe;
    e.res = m_res;
    e.fl  = m_fl;
    e.tag = tag_of(o);
    return e;
  endfunction

  // driver: called at a negedge, leaves the bench at the next negedge
  task automatic issue(input logic [3:0] o, input logic [1:0] s,
                       input logic [31:0] ia, input logic [31:0] ib);
    q.push_back(model(o, s, ia, ib));
    op = o; sz = s; a = ia; b = ib; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compares each response 2 ns after the edge that registers it
  bit   mon_due;
  exp_t mon_e;
  always @(posedge clk) begin
    mon_due = rst_n && valid;
    #2;
    if (mon_due) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1: response with empty scoreboard got %h expected none", result);
      end else begin
        mon_e = q.pop_front();
        check(mon_e.tag, {25'd0, wb, flags, result}, {25'd0, mon_e.wb, mon_e.fl, mon_e.res});
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1: watchdog expired got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13", {25'd0, wb, flags, result}, 64'd0);

    // R2 carry out at byte width, known flags: of0 sf0 zf1 af1 pf1 cf1
    issue(4'd0, 2'd0, 32'h0000_00ff, 32'h0000_0001);
    check("R2", {58'd0, flags}, {58'd0, 6'b001111});
    issue(4'd1, 2'd0, 32'h10, 32'h20);                 // R2 adc with carry in
    check("R2", {32'd0, result}, 64'h31);
    issue(4'd0, 2'd0, 32'h7f, 32'h01);                 // R4 positive overflow, R5 aux
    check("R4", {58'd0, flags}, {58'd0, 6'b110100});
    issue(4'd0, 2'd2, 32'h7fff_ffff, 32'h0000_0001);   // R4 32-bit
    issue(4'd0, 2'd1, 32'h8000, 32'h8000);             // R2 carry at 16
    issue(4'd2, 2'd1, 32'h0, 32'h1);                   // R3 borrow
    issue(4'd3, 2'd2, 32'h0, 32'h0);                   // R3 sbb with borrow in
    issue(4'd2, 2'd0, 32'h80, 32'h01);                 // R4 sub overflow
    issue(4'd2, 2'd0, 32'h10, 32'h01);                 // R5 borrow from bit 4
    issue(4'd7, 2'd0, 32'h80, 32'h0);                  // R3 neg of min
    issue(4'd7, 2'd1, 32'h0, 32'h0);                   // R3 neg of zero
    issue(4'd6, 2'd2, 32'h5, 32'h9);                   // R8 compare, result held
    check("R8", {32'd0, result}, {32'd0, m_res});
    issue(4'd12, 2'd0, 32'h0, 32'h0);                  // R11 stc
    issue(4'd4, 2'd0, 32'hff, 32'h0);                  // R7 inc keeps cf=1
    check("R7", {63'd0, flags[0]}, 64'd1);
    issue(4'd13, 2'd0, 32'h0, 32'h0);                  // R11 clc
    issue(4'd5, 2'd0, 32'h0, 32'h0);                   // R7 dec keeps cf=0
    check("R7", {63'd0, flags[0]}, 64'd0);
    issue(4'd14, 2'd0, 32'h0, 32'h0);                  // R11 cmc
    issue(4'd0, 2'd0, 32'hff, 32'hff);                 // set cf, af
    issue(4'd8, 2'd1, 32'hf0f0, 32'h0ff0);             // R9 and clears cf/af
    issue(4'd9, 2'd0, 32'h80, 32'h01);                 // R9 or sign
    issue(4'd10, 2'd2, 32'hdead_beef, 32'hdead_beef);  // R9 xor zero
    issue(4'd0, 2'd0, 32'h7f, 32'h01);                 // set of
    issue(4'd11, 2'd1, 32'h0000_1234, 32'h0);          // R10 not, flags kept
    check("R10", {32'd0, result}, 64'h0000_edcb);
    issue(4'd0, 2'd0, 32'h1234_5601, 32'habcd_ef01);   // R12 upper bits ignored
    check("R12", {32'd0, result}, 64'h2);
    issue(4'd11, 2'd0, 32'hffff_ff00, 32'h0);          // R12 not masked
    issue(4'd15, 2'd2, 32'h1, 32'h1);                  // R13 unused opcode
    issue(4'd0, 2'd3, 32'hffff_ffff, 32'h1);           // R12 size 3 is 32-bit
    // R1 idle: nothing moves
    @(negedge clk); @(negedge clk);
    check("R1", {25'd0, wb, flags, result}, {25'd0, 1'b0, m_fl, m_res});
    // R2 chained 64-bit add via adc
    issue(4'd0, 2'd2, 32'hffff_ffff, 32'h0000_0001);
    issue(4'd1, 2'd2, 32'h0000_0001, 32'h0000_0002);
    check("R2", {32'd0, result}, 64'h4);

    for (int i = 0; i < 600; i++) begin
      issue(4'($urandom % 16), 2'($urandom % 4), $urandom, $urandom);
      if ((i % 7) == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1: %0d responses missing expected 0", q.size());
    end
    finish_run();
  end
endmodule